// File: doc/BRIEF.md
# Slave-Mode Exposure Sequencer

This block generates the three exposure-control lines of an image sensor that is operated in slave mode. The main line sets the total exposure. Two secondary lines mark shorter windows that sit at the end of the main exposure, for dual-slope and triple-slope response. All three lines fall on one clock edge, and that shared falling edge tells the sensor to begin its frame overhead time. Each rising edge of the main line is placed directly after a falling edge of the sensor's row strobe, so exposure begins on a row boundary.

A single-cycle start pulse launches one frame, and a mode input chooses between two schedules. In the long-readout schedule, the main line rises at the first row-strobe falling edge that comes at least (readout length minus exposure length) cycles after start. All lines then drop directly after the falling edge of the last wanted row. In the short-readout schedule, the main line rises at the first row-strobe falling edge after a programmable reset period. All lines drop once the programmed exposure length has elapsed, and any rows beyond the wanted count are treated as dummies. A qualifier output marks only the rows that belong to the wanted window.

Top module: `slave_exposure_seq`

## Requirements
- R1: While `rstN` is low, `expMain`, `expDual`, `expTriple`, `busy`, `fotDone` and `keepLine` are low. The reset is asynchronous, so a reset in the middle of a frame clears the outputs at once.
- R2: A `start` pulse seen while idle makes `busy` high from the next cycle. A `start` seen while `busy` is high has no effect on the frame in progress. The exposure lines stay low whenever `busy` is low.
- R3: With `longMode`=0, `expMain` rises one cycle after the first clock edge at which `lineValid` is sampled low after being high, provided that at that edge at least `resetLen` cycles have passed since the cycle following the start edge.
- R4: With `longMode`=0, `expMain` stays high for exactly `expLen` cycles (a value of 0 is treated as 1), and then all exposure lines drop.
- R5: With `longMode`=1, `expMain` rises one cycle after the first `lineValid` falling edge at which at least max(`readLen`−`expLen`, 0) cycles have passed, with the count taken the same way as in R3.
- R6: With `longMode`=1, all exposure lines drop one cycle after the falling edge of row number `winLines` (rows are counted from 1 after start).
- R7: The effective length of a secondary line is max(length, 12). It rises at the cycle `expMain` rise + max(`expLen`−effective length, 12). A length of 0 disables the line, and so does a rise point at or past the end of the exposure.
- R8: All exposure lines that are high fall on the same cycle. On that cycle `fotDone` is high for exactly one cycle and `busy` goes low.
- R9: `keepLine` equals `lineValid` during a frame for the first `winLines` rows only. Later rows and rows seen while idle give `keepLine`=0.
- R10: A secondary line is never high while `expMain` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame launch pulse |
| longMode | input | 1 | 1 = readout longer than exposure, 0 = readout shorter |
| expLen | input | CNT_W | Total exposure length in cycles |
| dualLen | input | CNT_W | Dual-slope window length in cycles (0 = off) |
| tripleLen | input | CNT_W | Triple-slope window length in cycles (0 = off) |
| resetLen | input | CNT_W | Minimum reset period before exposure, short mode |
| readLen | input | CNT_W | Readout length in cycles, long mode |
| winLines | input | LINE_W | Number of wanted rows |
| lineValid | input | 1 | Row strobe from the sensor |
| expMain | output | 1 | Total exposure line |
| expDual | output | 1 | Dual-slope exposure line |
| expTriple | output | 1 | Triple-slope exposure line |
| busy | output | 1 | Frame in progress |
| fotDone | output | 1 | One-cycle pulse on the shared falling edge |
| keepLine | output | 1 | `lineValid` qualified to the wanted rows |

## Verification
The bench builds the block with its defaults (20-bit cycle counters, 10-bit row counter, 12-cycle minimum gap). It drives exposure lengths of only 10 to 100 cycles, so every schedule in a frame fits into 120 samples. These short lengths also reach each clamp path: a secondary window shorter than the gap, a secondary window that would start closer than 12 cycles to the main rise, an exposure too short to hold any secondary window, and a secondary rise in long mode that the row-counted end pre-empts. Row strobes keep running past the wanted count in every frame, so the dummy-row handling and the saturating row counter are exercised as well.

// File: rtl/slvexp_pkg.sv
package slvexp_pkg;
  localparam int NSEC = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_EXPOSE = 2'd2
  } expState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic clrInt;
  } expStrb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic            fall;
    logic            riseOk;
    logic            lastLine;
    logic            intDone;
    logic [NSEC-1:0] secHit;
  } expFlag_t;
endpackage

// File: rtl/slvexp_datapath.sv
module slvexp_datapath
  import slvexp_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int LINE_W  = 10,
  parameter int MIN_GAP = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineValid,
  input  logic                       longMode,
  input  logic [CNT_W-1:0]           expLen,
  input  logic [CNT_W-1:0]           resetLen,
  input  logic [CNT_W-1:0]           readLen,
  input  logic [NSEC-1:0][CNT_W-1:0] secLen,
  input  logic [LINE_W-1:0]          winLines,
  input  expStrb_t                   strb,
  output expFlag_t                   flag,
  output logic                       lineInWin
);
  localparam logic [CNT_W-1:0] GAP = CNT_W'(MIN_GAP);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic              lvQ;
  logic [CNT_W-1:0]  tCnt;
  logic [CNT_W-1:0]  iCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [CNT_W-1:0]  longStart;
  logic [NSEC-1:0]   secHit;
  logic              fall;

  assign fall = lvQ & ~lineValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvQ     <= 1'b0;
      tCnt    <= '0;
      iCnt    <= '0;
      lineCnt <= '0;
    end else begin
      lvQ <= lineValid;
      if (strb.clrFrame) begin
        tCnt    <= '0;
        lineCnt <= '0;
      end else begin
        if (tCnt != CMAX) tCnt <= tCnt + 1'b1;
        if (fall && (lineCnt < winLines)) lineCnt <= lineCnt + 1'b1;
      end
      if (strb.clrInt) iCnt <= '0;
      else if (iCnt != CMAX) iCnt <= iCnt + 1'b1;
    end
  end

  // secondary windows: rise point clamped to keep the minimum gap
  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    logic [CNT_W-1:0] secEff, secRaw, secThr;
    always_comb begin
      secEff = (secLen[k] > GAP) ? secLen[k] : GAP;
      secRaw = (expLen > secEff) ? expLen - secEff : '0;
      secThr = (secRaw > GAP) ? secRaw : GAP;
    end
    assign secHit[k] = (secLen[k] != '0) && (secThr < expLen) &&
                       (({1'b0, iCnt} + 1'b1) == {1'b0, secThr});
  end

  always_comb begin
    longStart     = (readLen > expLen) ? readLen - expLen : '0;
    flag.fall     = fall;
    flag.riseOk   = longMode ? (tCnt >= longStart) : (tCnt >= resetLen);
    flag.lastLine = fall && (({1'b0, lineCnt} + 1'b1) >= {1'b0, winLines});
    flag.intDone  = ({1'b0, iCnt} + 1'b1) >= {1'b0, expLen};
    flag.secHit   = secHit;
    lineInWin     = lineCnt < winLines;
  end
endmodule

// File: rtl/slvexp_control.sv
module slvexp_control
  import slvexp_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          longMode,
  input  expFlag_t      flag,
  output expStrb_t      strb,
  output logic [NSEC:0] expLines,
  output logic          busy,
  output logic          fotDone
);
  expState_t state;
  logic      endNow;

  always_comb begin
    endNow        = longMode ? flag.lastLine : flag.intDone;
    strb.clrFrame = (state == ST_IDLE) && start;
    strb.clrInt   = (state != ST_EXPOSE);
    busy          = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      expLines <= '0;
      fotDone  <= 1'b0;
    end else begin
      fotDone <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_WAIT;
        ST_WAIT: begin
          if (longMode && flag.lastLine) begin
            state   <= ST_IDLE;
            fotDone <= 1'b1;
          end else if (flag.fall && flag.riseOk) begin
            state       <= ST_EXPOSE;
            expLines[0] <= 1'b1;
          end
        end
        ST_EXPOSE: begin
          if (endNow) begin
            expLines <= '0;
            fotDone  <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            for (int k = 0; k < NSEC; k++)
              if (flag.secHit[k]) expLines[k+1] <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slave_exposure_seq.sv
module slave_exposure_seq
  import slvexp_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int LINE_W  = 10,
  parameter int MIN_GAP = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              longMode,
  input  logic [CNT_W-1:0]  expLen,
  input  logic [CNT_W-1:0]  dualLen,
  input  logic [CNT_W-1:0]  tripleLen,
  input  logic [CNT_W-1:0]  resetLen,
  input  logic [CNT_W-1:0]  readLen,
  input  logic [LINE_W-1:0] winLines,
  input  logic              lineValid,
  output logic              expMain,
  output logic              expDual,
  output logic              expTriple,
  output logic              busy,
  output logic              fotDone,
  output logic              keepLine
);
  expStrb_t                   strb;
  expFlag_t                   flag;
  logic                       lineInWin;
  logic [NSEC:0]              expLines;
  logic [NSEC-1:0][CNT_W-1:0] secLen;

  assign secLen = {tripleLen, dualLen};

  slvexp_datapath #(.CNT_W(CNT_W), .LINE_W(LINE_W), .MIN_GAP(MIN_GAP)) dp (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .longMode(longMode),
    .expLen(expLen), .resetLen(resetLen), .readLen(readLen), .secLen(secLen),
    .winLines(winLines), .strb(strb), .flag(flag), .lineInWin(lineInWin)
  );

  slvexp_control ctl (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode), .flag(flag),
    .strb(strb), .expLines(expLines), .busy(busy), .fotDone(fotDone)
  );

  assign expMain   = expLines[0];
  assign expDual   = expLines[1];
  assign expTriple = expLines[2];
  assign keepLine  = lineValid & busy & lineInWin;
endmodule

// File: rtl/slvexp_checker.sv
module slvexp_checker #(
  parameter int CNT_W   = 20,
  parameter int MIN_GAP = 12
) (
  input logic clk,
  input logic rstN,
  input logic lineValid,
  input logic expMain,
  input logic expDual,
  input logic expTriple,
  input logic busy,
  input logic fotDone
);
  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= '0;
    else if (!expMain) gapCnt <= '0;
    else if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
  end

  // R8
  common_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(expMain) && !expMain) |-> (!expDual && !expTriple && fotDone));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fotDone |=> !fotDone);

  // R10
  nested_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expDual || expTriple) |-> expMain);

  // R3
  row_aligned_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expMain) |-> (!$past(lineValid) && $past(lineValid, 2)));

  // R7
  sec_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(expDual) || $rose(expTriple)) |-> (gapCnt >= CNT_W'(MIN_GAP)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(expMain || expDual || expTriple));
endmodule

bind slave_exposure_seq slvexp_checker #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) chk (
  .clk(clk), .rstN(rstN), .lineValid(lineValid), .expMain(expMain),
  .expDual(expDual), .expTriple(expTriple), .busy(busy), .fotDone(fotDone)
);

// File: tb/slave_exposure_seq_test.sv
module slave_exposure_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 20;
  localparam int LINE_W = 10;
  localparam int GAP = 12;
  localparam int SAMPLES = 120;

  typedef struct packed {
    int longM; int intLen; int ds; int ts; int rst; int rdCyc;
    int rdLines; int lead; int per; int hi; int restart;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{0, 60, 20, 8, 15, 0, 3, 3, 10, 6, 40},
    '{0, 20, 15, 0, 0, 0, 2, 2, 8, 4, -1},
    '{0, 10, 30, 5, 4, 0, 1, 2, 6, 3, -1},
    '{1, 30, 14, 0, 0, 50, 6, 3, 10, 5, -1},
    '{1, 100, 90, 20, 0, 40, 3, 2, 12, 6, -1}
  };

  logic clk = 0, rstN = 0, start = 0, longMode = 0, lineValid = 0;
  logic [CNT_W-1:0] expLen = '0, dualLen = '0, tripleLen = '0, resetLen = '0, readLen = '0;
  logic [LINE_W-1:0] winLines = '0;
  logic expMain, expDual, expTriple, busy, fotDone, keepLine;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_exposure_seq #(.CNT_W(CNT_W), .LINE_W(LINE_W), .MIN_GAP(GAP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode), .expLen(expLen),
    .dualLen(dualLen), .tripleLen(tripleLen), .resetLen(resetLen), .readLen(readLen),
    .winLines(winLines), .lineValid(lineValid), .expMain(expMain), .expDual(expDual),
    .expTriple(expTriple), .busy(busy), .fotDone(fotDone), .keepLine(keepLine)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int secRise(input int len, input int intLen, input int sf, input int drop);
    int eff, raw, thr, r;
    eff = (len > GAP) ? len : GAP;
    raw = (intLen > eff) ? intLen - eff : 0;
    thr = (raw > GAP) ? raw : GAP;
    if (len == 0 || thr >= intLen) return -1;
    r = sf + thr + 1;
    return (r < drop) ? r : -1;
  endfunction

  task automatic runVec(input vec_t v);
    int thr, sf, eR1, eDrop, eR2, eR3;
    int r1, f1, r2, f2, r3, f3, di, dn, keep, nestBad, busyAt1, busyAtDrop;
    string rRise, rDrop;
    thr = v.longM != 0 ? ((v.rdCyc > v.intLen) ? v.rdCyc - v.intLen : 0) : v.rst;
    sf = -1;
    for (int n = 0; n < 20; n++) begin
      int f;
      f = v.lead + n * v.per + v.hi;
      if (sf < 0 && f - 1 >= thr) sf = f;
    end
    eR1 = sf + 1;
    eDrop = v.longM != 0 ? v.lead + (v.rdLines - 1) * v.per + v.hi + 1 : sf + v.intLen + 1;
    eR2 = secRise(v.ds, v.intLen, sf, eDrop);
    eR3 = secRise(v.ts, v.intLen, sf, eDrop);
    rRise = v.longM != 0 ? "R5 rise" : "R3 rise";
    rDrop = v.longM != 0 ? "R6 drop" : "R4 drop";

    longMode  = v.longM[0];
    expLen    = CNT_W'(v.intLen);
    dualLen   = CNT_W'(v.ds);
    tripleLen = CNT_W'(v.ts);
    resetLen  = CNT_W'(v.rst);
    readLen   = CNT_W'(v.rdCyc);
    winLines  = LINE_W'(v.rdLines);
    r1 = -1; f1 = -1; r2 = -1; f2 = -1; r3 = -1; f3 = -1; di = -1;
    dn = 0; keep = 0; nestBad = 0; busyAt1 = 0; busyAtDrop = 1;

    for (int s = 0; s < SAMPLES; s++) begin
      @(negedge clk);
      if (expMain && r1 < 0) r1 = s;
      if (!expMain && r1 >= 0 && f1 < 0) begin f1 = s; busyAtDrop = busy; end
      if (expDual && r2 < 0) r2 = s;
      if (!expDual && r2 >= 0 && f2 < 0) f2 = s;
      if (expTriple && r3 < 0) r3 = s;
      if (!expTriple && r3 >= 0 && f3 < 0) f3 = s;
      if (fotDone) begin dn++; if (di < 0) di = s; end
      if ((expDual || expTriple) && !expMain) nestBad++;
      if (s == 1) busyAt1 = busy;
      start = (s == 0) || (s == v.restart);
      lineValid = (s >= v.lead) && (((s - v.lead) % v.per) < v.hi);
      #1;
      if (keepLine) keep++;
    end
    start = 0;

    check("R2 busy after start", busyAt1, 1);
    check(rRise, r1, eR1);
    check(rDrop, f1, eDrop);
    check("R7 dual rise", r2, eR2);
    check("R7 triple rise", r3, eR3);
    if (r2 >= 0) check("R8 dual falls with main", f2, f1);
    if (r3 >= 0) check("R8 triple falls with main", f3, f1);
    check("R8 done cycle", di, eDrop);
    check("R8 done count", dn, 1);
    check("R8 busy low at drop", busyAtDrop, 0);
    check("R9 kept row samples", keep, v.rdLines * v.hi);
    check("R10 secondary outside main", nestBad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 main in reset", expMain, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", fotDone, 0);
    rstN = 1;
    lineValid = 1;
    @(negedge clk);
    #1;
    // R9 idle rows are not kept
    check("R9 keep while idle", keepLine, 0);
    check("R2 idle lines low", expMain | expDual | expTriple, 0);
    lineValid = 0;
    @(negedge clk);

    // R2 (restart ignored in first vector), R3..R10
    for (int i = 0; i < 5; i++) runVec(VECS[i]);

    // R1 reset in the middle of an exposure
    longMode = 0; expLen = 20'd60; dualLen = 20'd20; tripleLen = 20'd0;
    resetLen = 20'd0; winLines = 10'd3;
    for (int s = 0; s < 30; s++) begin
      @(negedge clk);
      start = (s == 0);
      lineValid = (s >= 2) && (((s - 2) % 8) < 4);
    end
    check("R1 main high before reset", expMain, 1);
    rstN = 0;
    #1;
    check("R1 main cleared by reset", expMain, 0);
    check("R1 busy cleared by reset", busy, 0);
    @(negedge clk);
    rstN = 1;
    lineValid = 0;
    start = 0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule